// File: doc/BRIEF.md
# Shadowed Nonvolatile Register Bank for a Nine-Pin Open-Drain Expander

This block holds the byte-addressed register and memory map behind a nine-pin open-drain I/O expander. A serial front end (not part of this block) turns bus transfers into single-cycle byte accesses on an 8-bit address and tells the bank when the bus transfer has ended through a one-cycle stop event. Nonvolatile storage is modelled as an internal byte array of nine 8-byte pages. Eight pages back the 64-byte user area. The ninth page backs the pin setup bytes at F0h–F3h and the three nonvolatile user bytes at F5h–F7h. Writing a nonvolatile page takes a programmable number of cycles.

A host write to nonvolatile space lands at once in a volatile working image and marks its page dirty. When the stop event arrives, every dirty page is copied whole into nonvolatile storage, one page after another, and the block reports busy for the whole time. Bit 0 of the configuration byte (F4h) is the shadow-only switch. While it is set, writes to the pin setup bytes change the live pin drive but are never scheduled for nonvolatile storage, so the pins can be updated without wear. After reset the bank copies nonvolatile storage back into the working image and the pin shadows. The pins stay released until that copy ends, and then come up in their programmed state.

Top module: `nvreg_bank`

## Requirements
- R1: User bytes 00h–3Fh and F5h–F7h and the volatile bytes FAh–FFh read back the last value written. The read data appears on `acc_rdata` one clock after the address is presented.
- R2: Addresses 40h–EFh read as 00h, and writes to them change no readable byte and no pin output.
- R3: For pin n (0 to 7), bit n of F2h set to 0 asserts `pin_drive_low[n]` and set to 1 releases the pin. Bit n of F0h set to 1 asserts `pin_pull_en[n]`. Pin 8 uses bit 0 of F3h and of F1h in the same way. Reads of F1h, F3h, F4h and F9h return 0 in bits 7:1.
- R4: The configuration byte at F4h resets to 00h. While its bit 0 is 1, writes to F0h–F3h update only the pin shadows and mark nothing dirty, so the nonvolatile copy keeps its old value across the next reset. While bit 0 is 0, such writes also go to nonvolatile storage.
- R5: F8h returns `pin_level[7:0]` and F9h returns `pin_level[8]` in bit 0, both sampled at the read. Writes to F8h and F9h leave every pin output unchanged.
- R6: A stop event with N dirty pages starts a commit: `busy` is high from the next cycle for exactly N*(8+WRITE_CYC) cycles. A stop event with no dirty page leaves `busy` low.
- R7: A commit rewrites the whole page, and bytes on that page that were not written keep their earlier values.
- R8: While `busy` is high, writes to every address are ignored.
- R9: After reset is released, `busy` stays high for 72 cycles with all pins released and all pullups off. Then the pin shadows and user bytes hold their nonvolatile values. Factory contents are 00h everywhere except F2h = FFh and F3h = 01h.
- R10: A write accepted in the same cycle as a stop event belongs to the commit that the stop event starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts nonvolatile recall |
| acc_we | input | 1 | Byte write strobe |
| acc_addr | input | 8 | Byte address for reads and writes |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data for the previous cycle's address |
| stop_evt | input | 1 | One-cycle pulse marking the end of a bus transfer |
| busy | output | 1 | High during recall and during nonvolatile commits |
| pin_level | input | 9 | Live logic levels seen on the nine pins |
| pin_drive_low | output | 9 | One per pin: pull-down transistor on |
| pin_pull_en | output | 9 | One per pin: internal pullup enabled |

## Verification
A host write and the stop event can fall in the same cycle. The write must then be counted as dirty before the commit decides how many pages to copy. The bench provokes this by raising the write strobe and the stop pulse in one cycle on an otherwise clean bank. It judges the result by the exact length of the busy window (one page) and by the value that the byte holds after a later reset. A second overlap is the edge on which recall ends while a write or read is presented. The bench's reference model ignores accesses during recall and compares outputs on every clock from then on.

// File: rtl/nvr_pkg.sv
`timescale 1ns/1ps
package nvr_pkg;
  localparam int PIN_N    = 9;
  localparam int PG_BYTES = 8;
  localparam int USER_N   = 64;
  localparam int NV_PAGES = USER_N / PG_BYTES + 1;
  localparam int NV_N     = NV_PAGES * PG_BYTES;
  localparam int IDX_W    = $clog2(NV_N);
  localparam int PGI_W    = $clog2(NV_PAGES);
  localparam int VRAM_N   = 6;

  localparam logic [7:0] A_PU0  = 8'hF0;
  localparam logic [7:0] A_PU1  = 8'hF1;
  localparam logic [7:0] A_CTL0 = 8'hF2;
  localparam logic [7:0] A_CTL1 = 8'hF3;
  localparam logic [7:0] A_CFG  = 8'hF4;
  localparam logic [7:0] A_ST0  = 8'hF8;
  localparam logic [7:0] A_ST1  = 8'hF9;
  localparam logic [7:0] A_VRAM = 8'hFA;

  typedef enum logic [1:0] {EN_RECALL, EN_IDLE, EN_COPY, EN_WAIT} eng_st_t;

  // lowest set page bit; commits run in ascending page order
  function automatic logic [PGI_W-1:0] low_page(input logic [NV_PAGES-1:0] m);
    logic [PGI_W-1:0] r;
    r = '0;
    for (int i = NV_PAGES - 1; i >= 0; i--) begin
      if (m[i]) r = PGI_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/nvr_nvstore.sv
`timescale 1ns/1ps
module nvr_nvstore
  import nvr_pkg::*;
(
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] mem [NV_N];

  // factory contents: everything clear, pins released
  initial begin
    for (int i = 0; i < NV_N; i++) mem[i] = 8'h00;
    mem[USER_N + 2] = 8'hFF;
    mem[USER_N + 3] = 8'h01;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      AST_NV_IN_RANGE: assert (addr < IDX_W'(NV_N)); // R7
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/nvr_engine.sv
`timescale 1ns/1ps
module nvr_engine
  import nvr_pkg::*;
#(
  parameter int WRITE_CYC = 4000000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stop_evt,
  input  logic [NV_PAGES-1:0] dirty_nx,
  output logic                go,
  output logic                idle,
  output logic                busy,
  output logic                rec_we,
  output logic                rec_done,
  output logic                cp_we,
  output logic [IDX_W-1:0]    mem_idx
);
  localparam int CNT_W = (WRITE_CYC > 1) ? $clog2(WRITE_CYC) : 1;

  eng_st_t             st;
  logic [IDX_W-1:0]    idx;
  logic [PGI_W-1:0]    page;
  logic [2:0]          byte_i;
  logic [CNT_W-1:0]    cnt;
  logic [NV_PAGES-1:0] pend;
  logic                busy_q;
  logic [PGI_W-1:0]    lp_new, lp_pend;

  assign lp_new   = low_page(dirty_nx);
  assign lp_pend  = low_page(pend);
  assign idle     = (st == EN_IDLE);
  assign go       = idle && stop_evt && (dirty_nx != '0);
  assign rec_we   = (st == EN_RECALL);
  assign rec_done = rec_we && (idx == IDX_W'(NV_N - 1));
  assign cp_we    = (st == EN_COPY);
  assign mem_idx  = rec_we ? idx : {page, byte_i};
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= EN_RECALL;
      idx    <= '0;
      page   <= '0;
      byte_i <= '0;
      cnt    <= '0;
      pend   <= '0;
      busy_q <= 1'b1;
    end else begin
      unique case (st)
        EN_RECALL: begin
          if (rec_done) begin
            st     <= EN_IDLE;
            busy_q <= 1'b0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        EN_IDLE: begin
          if (go) begin
            page   <= lp_new;
            pend   <= dirty_nx & ~(NV_PAGES'(1) << lp_new);
            byte_i <= '0;
            st     <= EN_COPY;
            busy_q <= 1'b1;
          end
        end
        EN_COPY: begin
          byte_i <= byte_i + 1'b1;
          if (byte_i == 3'd7) begin
            st  <= EN_WAIT;
            cnt <= '0;
          end
        end
        EN_WAIT: begin
          if (cnt == CNT_W'(WRITE_CYC - 1)) begin
            if (pend != '0) begin
              page   <= lp_pend;
              pend   <= pend & ~(NV_PAGES'(1) << lp_pend);
              byte_i <= '0;
              st     <= EN_COPY;
            end else begin
              st     <= EN_IDLE;
              busy_q <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

  AST_GO_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    go |=> busy); // R6
  AST_RECALL_RELEASES: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> !busy); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (idle && !go) |=> !busy); // R6
endmodule

// File: rtl/nvreg_bank.sv
`timescale 1ns/1ps
module nvreg_bank
  import nvr_pkg::*;
#(
  parameter int WRITE_CYC = 4000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_we,
  input  logic [7:0]       acc_addr,
  input  logic [7:0]       acc_wdata,
  output logic [7:0]       acc_rdata,
  input  logic             stop_evt,
  output logic             busy,
  input  logic [PIN_N-1:0] pin_level,
  output logic [PIN_N-1:0] pin_drive_low,
  output logic [PIN_N-1:0] pin_pull_en
);
  logic [7:0]          work [NV_N];
  logic [7:0]          vram [VRAM_N];
  logic [PIN_N-1:0]    pu_q, low_q;
  logic                cfg_q;
  logic [NV_PAGES-1:0] dirty_q, dirty_nx, wmark;
  logic                go, idle, rec_we, rec_done, cp_we;
  logic [IDX_W-1:0]    mem_idx, w_idx;
  logic                w_work, wr_ok;
  logic [7:0]          nv_rd, rd_mux;
  logic [2:0]          vi;

  assign wr_ok = acc_we && idle;
  assign vi    = 3'(acc_addr - A_VRAM);

  // decode of writes that reach the nonvolatile working image
  always_comb begin
    wmark  = '0;
    w_work = 1'b0;
    w_idx  = '0;
    if (wr_ok) begin
      if (acc_addr < 8'h40) begin
        w_work = 1'b1;
        w_idx  = {1'b0, acc_addr[5:0]};
        wmark[{1'b0, acc_addr[5:3]}] = 1'b1;
      end else if (acc_addr[7:3] == 5'b11110 && acc_addr != A_CFG &&
                   (acc_addr[2] || !cfg_q)) begin
        w_work = 1'b1;
        w_idx  = {4'd8, acc_addr[2:0]};
        wmark[NV_PAGES-1] = 1'b1;
      end
    end
  end

  assign dirty_nx = dirty_q | wmark;

  nvr_engine #(.WRITE_CYC(WRITE_CYC)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .stop_evt (stop_evt),
    .dirty_nx (dirty_nx),
    .go       (go),
    .idle     (idle),
    .busy     (busy),
    .rec_we   (rec_we),
    .rec_done (rec_done),
    .cp_we    (cp_we),
    .mem_idx  (mem_idx)
  );

  nvr_nvstore u_nv (
    .clk   (clk),
    .we    (cp_we),
    .addr  (mem_idx),
    .wdata (work[mem_idx]),
    .rdata (nv_rd)
  );

  always_ff @(posedge clk) begin
    if (rec_we)      work[mem_idx] <= nv_rd;
    else if (w_work) work[w_idx]   <= acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     dirty_q <= '0;
    else if (go) dirty_q <= '0;
    else         dirty_q <= dirty_nx;
  end

  // pin shadows: released until recall completes
  always_ff @(posedge clk) begin
    if (rst) begin
      pu_q  <= '0;
      low_q <= '0;
      cfg_q <= 1'b0;
    end else if (rec_done) begin
      pu_q  <= {work[USER_N + 1][0], work[USER_N]};
      low_q <= ~{work[USER_N + 3][0], work[USER_N + 2]};
    end else if (wr_ok) begin
      unique case (acc_addr)
        A_PU0:   pu_q[7:0] <= acc_wdata;
        A_PU1:   pu_q[8]   <= acc_wdata[0];
        A_CTL0:  low_q[7:0] <= ~acc_wdata;
        A_CTL1:  low_q[8]   <= ~acc_wdata[0];
        A_CFG:   cfg_q      <= acc_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < VRAM_N; i++) vram[i] <= 8'h00;
    end else if (wr_ok && acc_addr >= A_VRAM) begin
      vram[vi] <= acc_wdata;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (acc_addr < 8'h40) begin
      rd_mux = work[{1'b0, acc_addr[5:0]}];
    end else if (acc_addr >= A_VRAM) begin
      rd_mux = vram[vi];
    end else begin
      unique case (acc_addr)
        A_PU0:   rd_mux = pu_q[7:0];
        A_PU1:   rd_mux = {7'b0, pu_q[8]};
        A_CTL0:  rd_mux = ~low_q[7:0];
        A_CTL1:  rd_mux = {7'b0, ~low_q[8]};
        A_CFG:   rd_mux = {7'b0, cfg_q};
        8'hF5, 8'hF6, 8'hF7: rd_mux = work[{4'd8, acc_addr[2:0]}];
        A_ST0:   rd_mux = pin_level[7:0];
        A_ST1:   rd_mux = {7'b0, pin_level[8]};
        default: rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_rdata <= 8'h00;
    else     acc_rdata <= rd_mux;
  end

  assign pin_drive_low = low_q;
  assign pin_pull_en   = pu_q;

  AST_RECALL_PINS_FREE: assert property (@(posedge clk) disable iff (rst)
    rec_we |-> (pin_drive_low == '0 && pin_pull_en == '0)); // R9
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_addr >= 8'h40 && acc_addr <= 8'hEF) |=> (acc_rdata == 8'h00)); // R2
  AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (acc_we && idle && (acc_addr == A_ST0 || acc_addr == A_ST1))
      |=> ($stable(pin_drive_low) && $stable(pin_pull_en))); // R5
  AST_SHADOW_ONLY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && cfg_q && !stop_evt && acc_addr[7:2] == 6'b111100)
      |=> $stable(dirty_q)); // R4
  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (acc_we && !idle && !rec_done) |=> ($stable(cfg_q) && $stable(pin_pull_en))); // R8
endmodule

// File: tb/nvreg_bank_bench.sv
`timescale 1ns/1ps
module nvreg_bank_bench;
  localparam int WC  = 5;
  localparam int NVN = 72;
  localparam int PG  = 8 + WC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we = 1'b0, stop = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [8:0] pin_lv = 9'h000;
  logic [7:0] rdata;
  logic       busy;
  logic [8:0] drv_low, pull_en;

  always #2.5 clk = ~clk;

  nvreg_bank #(.WRITE_CYC(WC)) u_nvreg_bank (
    .clk(clk), .rst(rst), .acc_we(we), .acc_addr(addr), .acc_wdata(wdata),
    .acc_rdata(rdata), .stop_evt(stop), .busy(busy), .pin_level(pin_lv),
    .pin_drive_low(drv_low), .pin_pull_en(pull_en)
  );

  // behavioural reference model
  logic [7:0] m_work [NVN];
  logic [7:0] m_nv   [NVN];
  logic [7:0] m_vr   [6];
  logic [8:0] m_pu, m_low, m_dirty;
  logic       m_cfg;
  int         m_rec, m_bcnt;
  logic [7:0] m_rd;
  bit         m_rdv;
  int         n_cmp = 0, n_bad = 0;

  initial begin
    for (int i = 0; i < NVN; i++) begin m_nv[i] = 8'h00; m_work[i] = 8'h00; end
    m_nv[66] = 8'hFF;
    m_nv[67] = 8'h01;
  end

  function automatic logic [7:0] mread(input logic [7:0] a);
    if (a < 8'h40) return m_work[a];
    if (a >= 8'hFA) return m_vr[a - 8'hFA];
    case (a)
      8'hF0: return m_pu[7:0];
      8'hF1: return {7'b0, m_pu[8]};
      8'hF2: return ~m_low[7:0];
      8'hF3: return {7'b0, ~m_low[8]};
      8'hF4: return {7'b0, m_cfg};
      8'hF5, 8'hF6, 8'hF7: return m_work[64 + a - 8'hF0];
      8'hF8: return pin_lv[7:0];
      8'hF9: return {7'b0, pin_lv[8]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [7:0] d);
    if (a < 8'h40) begin
      m_work[a] = d;
      m_dirty[a >> 3] = 1'b1;
    end else if (a >= 8'hFA) begin
      m_vr[a - 8'hFA] = d;
    end else if (a >= 8'hF0 && a <= 8'hF3) begin
      case (a)
        8'hF0: m_pu[7:0] = d;
        8'hF1: m_pu[8] = d[0];
        8'hF2: m_low[7:0] = ~d;
        default: m_low[8] = ~d[0];
      endcase
      if (!m_cfg) begin m_work[64 + a - 8'hF0] = d; m_dirty[8] = 1'b1; end
    end else if (a == 8'hF4) begin
      m_cfg = d[0];
    end else if (a >= 8'hF5 && a <= 8'hF7) begin
      m_work[64 + a - 8'hF0] = d;
      m_dirty[8] = 1'b1;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_rec = NVN; m_bcnt = 0; m_pu = '0; m_low = '0; m_cfg = 1'b0;
      m_dirty = '0; m_rd = 8'h00; m_rdv = 1'b0;
      for (int i = 0; i < 6; i++) m_vr[i] = 8'h00;
    end else begin
      m_rdv = (m_rec == 0);
      m_rd  = mread(addr);
      if (m_rec > 0) begin
        m_rec--;
        if (m_rec == 0) begin
          for (int i = 0; i < NVN; i++) m_work[i] = m_nv[i];
          m_pu  = {m_nv[65][0], m_nv[64]};
          m_low = ~{m_nv[67][0], m_nv[66]};
        end
      end else if (m_bcnt > 0) begin
        m_bcnt--;
      end else begin
        if (we) mwrite(addr, wdata);
        if (stop && m_dirty != '0) begin
          m_bcnt = $countones(m_dirty) * PG;
          for (int p = 0; p < 9; p++)
            if (m_dirty[p]) for (int b = 0; b < 8; b++) m_nv[p*8+b] = m_work[p*8+b];
          m_dirty = '0;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6", "busy", int'(busy), int'(m_rec > 0 || m_bcnt > 0));
      chk("R3", "pin_drive_low", int'(drv_low), int'(m_low));
      chk("R3", "pin_pull_en", int'(pull_en), int'(m_pu));
      if (m_rdv) chk("R1", "acc_rdata", int'(rdata), int'(m_rd));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    chk(tag, $sformatf("read %02h", a), int'(rdata), int'(exp));
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic count_busy(inout int n);
    int lim = 0;
    while (busy && lim < 2000) begin n++; lim++; @(negedge clk); end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int n;
    pin_lv = 9'h0A5;
    do_reset();
    // R9: recall window with pins released
    chk("R9", "busy after reset", int'(busy), 1);
    chk("R9", "pins released", int'(drv_low | pull_en), 0);
    n = 1; count_busy(n);
    chk("R9", "recall length", n, NVN);
    rd(8'hF2, 8'hFF, "R9"); rd(8'hF3, 8'h01, "R9");
    rd(8'hF0, 8'h00, "R9"); rd(8'hF4, 8'h00, "R4");
    rd(8'h10, 8'h00, "R9");

    // R3: pin setup, nonvolatile mode
    wr(8'hF2, 8'h5A); wr(8'hF3, 8'h00); wr(8'hF0, 8'h0F); wr(8'hF1, 8'hFF);
    chk("R3", "drive low", int'(drv_low), 'h1A5);
    chk("R3", "pullups", int'(pull_en), 'h10F);
    rd(8'hF1, 8'h01, "R3"); rd(8'hF3, 8'h00, "R3");

    // R1 user and volatile bytes
    wr(8'h00, 8'h11); wr(8'h07, 8'h77); wr(8'h3F, 8'hEE); wr(8'hF5, 8'hC3);
    wr(8'hFA, 8'h99); wr(8'hFF, 8'h42);
    rd(8'h3F, 8'hEE, "R1"); rd(8'hFA, 8'h99, "R1"); rd(8'hF5, 8'hC3, "R1");

    // R2 reserved space
    wr(8'h50, 8'hAB);
    rd(8'h50, 8'h00, "R2"); rd(8'hE9, 8'h00, "R2");

    // R5 status
    pin_lv = 9'h0F0; rd(8'hF8, 8'hF0, "R5"); rd(8'hF9, 8'h00, "R5");
    pin_lv = 9'h1FF; rd(8'hF9, 8'h01, "R5");
    wr(8'hF8, 8'h00); wr(8'hF9, 8'h00);
    chk("R5", "pins after status write", int'(drv_low), 'h1A5);

    // R6/R8: three dirty pages, writes during busy ignored
    pulse_stop();
    n = 0;
    wr(8'h20, 8'h55); n++;
    wr(8'hF4, 8'h01); n++;
    count_busy(n);
    chk("R6", "commit length", n, 3 * PG);
    rd(8'h20, 8'h00, "R8"); rd(8'hF4, 8'h00, "R8");

    pulse_stop();
    chk("R6", "stop with nothing dirty", int'(busy), 0);

    // R4 shadow-only writes
    wr(8'hF4, 8'h01);
    wr(8'hF2, 8'h00);
    chk("R4", "shadow drive", int'(drv_low), 'h1FF);
    pulse_stop();
    chk("R4", "no commit in shadow-only", int'(busy), 0);

    // R10 write and stop in the same cycle
    we = 1'b1; addr = 8'h21; wdata = 8'h66; stop = 1'b1;
    @(negedge clk);
    we = 1'b0; stop = 1'b0;
    n = 0; count_busy(n);
    chk("R10", "same-cycle commit length", n, PG);

    // R7/R9 recall of committed values
    do_reset();
    n = 1; count_busy(n);
    rd(8'hF2, 8'h5A, "R4"); rd(8'hF4, 8'h00, "R4");
    rd(8'h00, 8'h11, "R7"); rd(8'h01, 8'h00, "R7"); rd(8'h07, 8'h77, "R7");
    rd(8'h21, 8'h66, "R10"); rd(8'h20, 8'h00, "R8");
    rd(8'hF5, 8'hC3, "R7"); rd(8'hFA, 8'h00, "R1");
    chk("R9", "recalled drive", int'(drv_low), 'h1A5);
    chk("R9", "recalled pullups", int'(pull_en), 'h10F);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule